// File: doc/BRIEF.md
# Floating-Point Exception Control and Sticky Status Register

This block holds the exception controls and the exception history of an embedded floating-point unit. It keeps five enable bits and five sticky bits, one of each per exception kind: invalid, divide-by-zero, underflow, overflow and inexact. It also keeps the flags of the most recent operation. Each time the arithmetic unit completes an operation it strobes `op_valid` and presents that operation's five exception flags. The block then copies the flags into the last-operation field and ORs them into the sticky field. From the enables it decides whether to raise a data interrupt request, a round interrupt request, or neither.

Software reads the whole register on `reg_rdata` and writes the enable and sticky fields through `reg_wr` and `reg_wdata`. Only software can clear a sticky bit. Hardware can only set one. When a software write and a hardware set meet on the same bit in the same cycle, the set wins, so no exception is lost. The interrupt requests are single-cycle pulses that go to an interrupt controller outside this block.

Top module: `fpx_csr`

## Requirements
- R1: After a synchronous active-low reset, the whole register reads zero and both interrupt requests are low.
- R2: Within each 5-bit field, bit 0 is invalid, bit 1 is divide-by-zero, bit 2 is underflow, bit 3 is overflow and bit 4 is inexact. `reg_rdata` is laid out as enables in [4:0], sticky in [9:5] and last-operation flags in [14:10]. `reg_wdata` is laid out as enables in [4:0] and sticky in [9:5].
- R3: A clock edge with `op_valid` high ORs `op_flags` into the sticky field and replaces the last-operation field with `op_flags`.
- R4: A clock edge with `op_valid` low and `reg_wr` low leaves the register unchanged and raises no interrupt request.
- R5: Hardware never clears a sticky bit. A sticky bit stays set across later operations whose matching flag is clear.
- R6: A clock edge with `reg_wr` high loads the enable and sticky fields from `reg_wdata`, so software can clear sticky bits. The last-operation field cannot be written.
- R7: When a software write and an operation flag target the same sticky bit in the same cycle, the bit ends up set.
- R8: `data_irq` is high for exactly the cycle after an edge where `op_valid` was high and at least one of the invalid, divide-by-zero, underflow or overflow flags was set with its enable set.
- R9: `round_irq` is high for exactly the cycle after an edge where `op_valid` was high and both the inexact flag and its enable were set.
- R10: A flag whose enable is clear raises no interrupt request, but it still updates the sticky and last-operation fields.
- R11: An operation is judged against the enables held before the edge that samples it. A write to the enables on that same edge affects only later operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation completes this cycle |
| op_flags | input | 5 | Exception flags of the completing operation |
| reg_wr | input | 1 | Software write strobe |
| reg_wdata | input | 10 | Write data: sticky [9:5], enables [4:0] |
| reg_rdata | output | 15 | Read data: last-op flags [14:10], sticky [9:5], enables [4:0] |
| data_irq | output | 1 | Data interrupt request pulse |
| round_irq | output | 1 | Round (inexact) interrupt request pulse |

## Verification
Every result of this block appears one edge after the inputs that cause it. The register fields and both interrupt pulses are valid just after the edge that samples `op_valid`, `op_flags` and `reg_wr`. The driver applies inputs on the falling edge and pushes the register value and pulse levels it expects after the next rising edge. The monitor pops and compares one item a short delay after every rising edge, so each comparison lands in the one cycle where that result is due. Corner cases covered include write-versus-set collisions on the same bit, writes to the enables on the same edge as an operation, and masked flags.

// File: rtl/fpx_pkg.sv
// Package: shared field sizes, bit indices and register layout for the
// floating-point exception register. Assumes five exception kinds.
package fpx_pkg;
    localparam int NUM_EXC  = 5;
    localparam int IDX_INV  = 0;
    localparam int IDX_DBZ  = 1;
    localparam int IDX_UNF  = 2;
    localparam int IDX_OVF  = 3;
    localparam int IDX_INX  = 4;
    localparam int EN_LSB   = 0;
    localparam int STK_LSB  = EN_LSB + NUM_EXC;
    localparam int STS_LSB  = STK_LSB + NUM_EXC;
    localparam int WDATA_W  = STS_LSB;
    localparam int RDATA_W  = STS_LSB + NUM_EXC;
    typedef logic [NUM_EXC-1:0] exc_vec_t;
endpackage

// File: rtl/fpx_enable_reg.sv
// Module: exception enable register. Software-written only; hardware never
// changes it. Assumes reg_wr is a single-cycle qualified write strobe.
module fpx_enable_reg
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sw_wr,
    input  exc_vec_t sw_enable,
    output exc_vec_t enable
);
    // Load enables on a software write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable <= '0;
        else if (sw_wr)
            enable <= sw_enable;
    end

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> $stable(enable)); // R4
endmodule

// File: rtl/fpx_sticky_bank.sv
// Module: sticky and last-operation flag storage, one slice per exception
// kind. A hardware set beats a software write on the same bit and cycle.
// Assumes op_flags is meaningful only while op_valid is high.
module fpx_sticky_bank
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_valid,
    input  exc_vec_t op_flags,
    input  logic     sw_wr,
    input  exc_vec_t sw_sticky,
    output exc_vec_t sticky,
    output exc_vec_t status
);
    for (genvar i = 0; i < NUM_EXC; i++) begin : g_slice
        logic set_i;
        logic base_i;

        // Decide the hardware set and the software-selected base value.
        always_comb begin
            set_i  = op_valid & op_flags[i];
            base_i = sw_wr ? sw_sticky[i] : sticky[i];
        end

        // Sticky bit: base value ORed with the hardware set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                sticky[i] <= 1'b0;
            else
                sticky[i] <= base_i | set_i;
        end

        // Last-operation flag: overwritten on every valid operation.
        always_ff @(posedge clk) begin
            if (!rst_n)
                status[i] <= 1'b0;
            else if (op_valid)
                status[i] <= op_flags[i];
        end
    end

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ((sticky & $past(op_flags)) == $past(op_flags))); // R7
    AST_STICKY_NO_HW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_wr |=> ((sticky & $past(sticky)) == $past(sticky))); // R5
    AST_STICKY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !sw_wr) |=> ($stable(sticky) && $stable(status))); // R4
    AST_STATUS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (status == $past(op_flags))); // R3
endmodule

// File: rtl/fpx_irq_gen.sv
// Module: interrupt request decode. It registers one-cycle data and round
// request pulses from the flags and enables in effect before the edge.
// Assumes the interrupt controller samples a pulse in its single cycle.
module fpx_irq_gen
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     op_valid,
    input  exc_vec_t op_flags,
    input  exc_vec_t enable,
    output logic     data_irq,
    output logic     round_irq
);
    localparam exc_vec_t DATA_MASK = exc_vec_t'((1 << IDX_INV) | (1 << IDX_DBZ) |
                                                (1 << IDX_UNF) | (1 << IDX_OVF));
    exc_vec_t hit;
    logic     data_req;
    logic     round_req;

    // Find the enabled flags of the completing operation.
    always_comb begin
        hit       = op_valid ? (op_flags & enable) : '0;
        data_req  = |(hit & DATA_MASK);
        round_req = hit[IDX_INX];
    end

    // Register the requests into single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_irq  <= 1'b0;
            round_irq <= 1'b0;
        end else begin
            data_irq  <= data_req;
            round_irq <= round_req;
        end
    end

    AST_DATA_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
        data_irq |-> $past(op_valid)); // R8
    AST_ROUND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        round_irq |-> ($past(enable[IDX_INX]) && $past(op_flags[IDX_INX]))); // R9
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |=> (!data_irq && !round_irq)); // R10
endmodule

// File: rtl/fpx_csr.sv
// Module: top of the floating-point exception control/status register.
// It joins the enable register, the sticky bank and the interrupt decode,
// and presents one read word. Assumes a single register address decoded
// outside this block into reg_wr.
module fpx_csr
    import fpx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [NUM_EXC-1:0] op_flags,
    input  logic               reg_wr,
    input  logic [WDATA_W-1:0] reg_wdata,
    output logic [RDATA_W-1:0] reg_rdata,
    output logic               data_irq,
    output logic               round_irq
);
    exc_vec_t enable;
    exc_vec_t sticky;
    exc_vec_t status;

    fpx_enable_reg u_en (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_wr     (reg_wr),
        .sw_enable (reg_wdata[EN_LSB +: NUM_EXC]),
        .enable    (enable)
    );

    fpx_sticky_bank u_stk (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_flags  (op_flags),
        .sw_wr     (reg_wr),
        .sw_sticky (reg_wdata[STK_LSB +: NUM_EXC]),
        .sticky    (sticky),
        .status    (status)
    );

    fpx_irq_gen u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_flags  (op_flags),
        .enable    (enable),
        .data_irq  (data_irq),
        .round_irq (round_irq)
    );

    // Assemble the read word from the three fields.
    always_comb begin
        reg_rdata                       = '0;
        reg_rdata[EN_LSB  +: NUM_EXC]   = enable;
        reg_rdata[STK_LSB +: NUM_EXC]   = sticky;
        reg_rdata[STS_LSB +: NUM_EXC]   = status;
    end

    AST_NO_IRQ_IN_RESET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!data_irq && !round_irq)); // R1
endmodule

// File: tb/fpx_csr_bench.sv
// Scoreboard bench: the driver task pushes expected results; the monitor
// pops and compares them just after each rising edge.
module fpx_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_flags = '0;
    logic        reg_wr = 1'b0;
    logic [9:0]  reg_wdata = '0;
    logic [14:0] reg_rdata;
    logic        data_irq;
    logic        round_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [14:0] rd;
        logic        di;
        logic        ri;
        string       tag;
    } exp_t;
    exp_t q[$];

    logic [4:0] m_en = '0, m_stk = '0, m_sts = '0;

    always #5 clk = ~clk;

    fpx_csr u_fpx_csr (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .data_irq(data_irq), .round_irq(round_irq)
    );

    // Drive one cycle and queue the result expected after the next edge.
    task automatic step(input logic v, input logic [4:0] f, input logic w,
                        input logic [9:0] wd, input string tag);
        exp_t e;
        @(negedge clk);
        op_valid = v; op_flags = f; reg_wr = w; reg_wdata = wd;
        e.di  = v && |(f[3:0] & m_en[3:0]);
        e.ri  = v && f[4] && m_en[4];
        m_stk = (w ? wd[9:5] : m_stk) | (v ? f : 5'b0);
        m_sts = v ? f : m_sts;
        m_en  = w ? wd[4:0] : m_en;
        e.rd  = {m_sts, m_stk, m_en};
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare one queued item per rising edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (reg_rdata !== e.rd || data_irq !== e.di || round_irq !== e.ri) begin
                errors++;
                $display("FAIL %s: rdata=%h dirq=%b rirq=%b expected rdata=%h dirq=%b rirq=%b",
                         e.tag, reg_rdata, data_irq, round_irq, e.rd, e.di, e.ri);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        checks++;
        if (reg_rdata !== '0 || data_irq !== 1'b0 || round_irq !== 1'b0) begin
            errors++;
            $display("FAIL R1: rdata=%h dirq=%b rirq=%b expected 0 0 0", reg_rdata, data_irq, round_irq);
        end
        // R10: masked flags update fields only
        step(1, 5'b00001, 0, '0, "R10 masked invalid");
        step(1, 5'b10000, 0, '0, "R10 masked inexact");
        // R4: idle
        step(0, 5'b11111, 0, '0, "R4 idle ignores flags");
        // R6: software clears sticky, sets all enables
        step(0, '0, 1, {5'b00000, 5'b11111}, "R6 clear sticky, enable all");
        // R2/R8: each data flag alone
        step(1, 5'b00001, 0, '0, "R2 R8 invalid");
        step(1, 5'b00010, 0, '0, "R2 R8 divzero");
        step(1, 5'b00100, 0, '0, "R2 R8 underflow");
        step(1, 5'b01000, 0, '0, "R2 R8 overflow");
        // R9: inexact
        step(1, 5'b10000, 0, '0, "R9 inexact");
        step(1, 5'b00000, 0, '0, "R5 no flags keeps sticky");
        step(0, '0, 0, '0, "R4 idle");
        // R6: status field not writable; clear sticky
        step(0, '0, 1, {5'b00000, 5'b11111}, "R6 clear sticky, status kept");
        // R7: clear and set the same bit in one cycle
        step(1, 5'b01000, 1, {5'b00000, 5'b11111}, "R7 set beats clear");
        // R11: disable on the same edge as an operation
        step(1, 5'b10001, 1, {5'b11111, 5'b00000}, "R11 old enables apply");
        step(1, 5'b10001, 0, '0, "R11 new enables apply");
        // R8: partial enables
        step(0, '0, 1, {5'b00000, 5'b00100}, "R6 enable underflow only");
        step(1, 5'b11011, 0, '0, "R8 masked data flags");
        step(1, 5'b00110, 0, '0, "R8 enabled underflow");
        step(0, '0, 0, '0, "R4 final idle");
        @(negedge clk);
        op_valid = 0; reg_wr = 0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule